// File: doc/BRIEF.md
# Field Memory Serial Write Port

This block is the write side of a sequential-access field memory. A single write clock drives it. Each clock edge samples a 12-bit data word, a write-restart strobe, a write enable and an input enable. An internal write pointer selects the next address. Accepted words are first collected in a staging register that holds one group of words. Each group is then moved into a small synchronous memory array, so the array takes one wide row write instead of a write for every word.

A restart strobe clears the pointer and begins a new write sequence. It also pushes any partly filled group into the array at the addresses that group was captured for. The write enable gates both data capture and pointer advance. The input enable only masks the array write of each word, and the pointer keeps moving regardless. Two sticky flags report misuse of the restart strobe: restarts that come too close together, and sequences that are too short. A registered read port exposes the array to the read side of the memory.

Top module: `fieldmem_wr_port`

## Requirements
- R1: While the synchronous reset `rst` is high, the pointer, both error flags and all staged words are cleared. Words that were staged before the reset never reach the array.
- R2: An edge that samples `wr_restart` high sets `wr_ptr` to 0. On that edge `wr_en`, `in_en` and `din` are ignored: nothing is captured and nothing from that edge is written to the array.
- R3: A rising `wr_restart` seen after fewer than two consecutive low samples sets the sticky flag `err_spacing`. Two or more low samples do not set it.
- R4: With `wr_restart` low and `wr_en` high, an edge captures `din` and advances `wr_ptr` by one. With `wr_en` low, `wr_ptr` holds its value and `din` is not captured.
- R5: A word captured with `in_en` low leaves its array address unchanged, but the pointer still advances for it.
- R6: The pointer wraps from DEPTH-1 (255 by default) to 0.
- R7: A rising `wr_restart` that ends a sequence with fewer than MIN_ACTIVE (80) write-enabled edges since the previous restart sets the sticky flag `err_short`. Exactly 80 does not set it. The first restart after `rst` performs no length check.
- R8: Words form groups of GROUP (8) consecutive addresses, aligned to a multiple of GROUP. A group is written to the array on the edge after the edge that captured its last word (address offset GROUP-1 within the group).
- R9: A partly filled group stays out of the array until a restart edge. The edge after that restart writes the staged words to the addresses they were captured for, not to the cleared pointer's addresses.
- R10: `rd_data` presents the array word at the `rd_addr` sampled on the previous edge. A read on the same edge as an array write to that address returns the old word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock; every input is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high system reset |
| din | input | 12 | Serial input data word |
| wr_restart | input | 1 | Write sequence restart: clears the pointer and flushes staged words |
| wr_en | input | 1 | Write enable: gates capture and pointer advance |
| in_en | input | 1 | Input enable: masks the array write of the captured word |
| rd_addr | input | 8 | Read address into the array |
| rd_data | output | 12 | Registered array word for the previous `rd_addr` |
| wr_ptr | output | 8 | Current write pointer (next address to be captured) |
| err_spacing | output | 1 | Sticky: restart re-asserted too soon |
| err_short | output | 1 | Sticky: sequence shorter than the minimum length |

## Verification
Most internal faults in this block show up late. A wrong pointer shows at `wr_ptr` on the very next edge. A wrong staging slot, group mask or commit row, however, only becomes visible when the affected array address is read, two edges after the commit at the earliest. A word flushed to the wrong row corrupts addresses far from the current pointer and can stay hidden for a whole sequence. For that reason the bench reads back the whole array after a full wrapped pass, and it reads specific addresses around masked words, staged tails and restart edges. An error in the restart-spacing or length counters shows on the flag outputs one edge after the offending restart.

// File: rtl/fmw_pkg.sv
package fmw_pkg;
  localparam int FMW_DATA_W   = 12;
  localparam int FMW_DEPTH    = 256;
  localparam int FMW_GROUP    = 8;
  localparam int FMW_MIN_RUN  = 80;
  localparam int FMW_GAP_LOWS = 2;
endpackage

// File: rtl/fmw_ctrl.sv
module fmw_ctrl
  import fmw_pkg::*;
#(
  parameter int DEPTH      = FMW_DEPTH,
  parameter int MIN_ACTIVE = FMW_MIN_RUN,
  parameter int AW         = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_restart,
  input  logic          wr_en,
  output logic [AW-1:0] ptr,
  output logic          capture,
  output logic          flush,
  output logic          err_spacing,
  output logic          err_short
);
  localparam int CW = $clog2(MIN_ACTIVE + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] MINV = CW'(MIN_ACTIVE);
  localparam logic [1:0]    GAPV = 2'(FMW_GAP_LOWS);

  logic          restart_q;
  logic [1:0]    low_cnt;
  logic          seq_open;
  logic [CW-1:0] act_cnt;
  logic          rise;

  assign rise    = wr_restart & ~restart_q;
  assign capture = wr_en & ~wr_restart;
  assign flush   = wr_restart;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr         <= '0;
      restart_q   <= 1'b0;
      low_cnt     <= GAPV;
      seq_open    <= 1'b0;
      act_cnt     <= '0;
      err_spacing <= 1'b0;
      err_short   <= 1'b0;
    end else begin
      restart_q <= wr_restart;
      if (wr_restart)           low_cnt <= 2'd0;
      else if (low_cnt != GAPV) low_cnt <= low_cnt + 2'd1;

      if (rise && (low_cnt < GAPV))                   err_spacing <= 1'b1;
      if (rise && seq_open && (act_cnt < MINV))        err_short   <= 1'b1;

      if (wr_restart) begin
        ptr      <= '0;
        seq_open <= 1'b1;
        act_cnt  <= '0;
      end else if (wr_en) begin
        ptr <= (ptr == LAST) ? '0 : ptr + AW'(1);
        if (act_cnt < MINV) act_cnt <= act_cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/fmw_stage.sv
module fmw_stage
  import fmw_pkg::*;
#(
  parameter int DW    = FMW_DATA_W,
  parameter int GROUP = FMW_GROUP,
  parameter int SW    = $clog2(GROUP),
  parameter int RW    = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       capture,
  input  logic                       flush,
  input  logic [DW-1:0]              din,
  input  logic                       ien,
  input  logic [SW-1:0]              slot,
  input  logic [RW-1:0]              row,
  output logic                       pending,
  output logic                       c_valid,
  output logic [RW-1:0]              c_row,
  output logic [GROUP-1:0]           c_we,
  output logic [GROUP-1:0][DW-1:0]   c_data
);
  localparam logic [SW-1:0] TOP_SLOT = SW'(GROUP - 1);

  logic [GROUP-1:0][DW-1:0] sd, sd_nxt;
  logic [GROUP-1:0]         sv, sv_nxt, sm, sm_nxt;
  logic                     last, do_flush;

  always_comb begin
    sd_nxt = sd;
    sv_nxt = sv;
    sm_nxt = sm;
    if (capture) begin
      sd_nxt[slot] = din;
      sv_nxt[slot] = 1'b1;
      sm_nxt[slot] = ien;
    end
  end

  assign last     = capture && (slot == TOP_SLOT);
  assign pending  = |sv;
  assign do_flush = flush && pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      sv      <= '0;
      sm      <= '0;
      c_valid <= 1'b0;
      c_row   <= '0;
      c_we    <= '0;
    end else begin
      c_valid <= 1'b0;
      sm      <= sm_nxt;
      if (last) begin
        c_valid <= 1'b1;
        c_row   <= row;
        c_we    <= sv_nxt & sm_nxt;
        sv      <= '0;
      end else if (do_flush) begin
        c_valid <= 1'b1;
        c_row   <= row;
        c_we    <= sv & sm;
        sv      <= '0;
      end else begin
        sv <= sv_nxt;
      end
    end
  end

  always_ff @(posedge clk) begin
    sd <= sd_nxt;
    if (last)          c_data <= sd_nxt;
    else if (do_flush) c_data <= sd;
  end
endmodule

// File: rtl/fmw_array.sv
module fmw_array
  import fmw_pkg::*;
#(
  parameter int DW    = FMW_DATA_W,
  parameter int GROUP = FMW_GROUP,
  parameter int ROWS  = FMW_DEPTH / FMW_GROUP,
  parameter int SW    = $clog2(GROUP),
  parameter int RW    = $clog2(ROWS)
) (
  input  logic                     clk,
  input  logic                     w_valid,
  input  logic [RW-1:0]            w_row,
  input  logic [GROUP-1:0]         w_en,
  input  logic [GROUP-1:0][DW-1:0] w_data,
  input  logic [RW-1:0]            r_row,
  input  logic [SW-1:0]            r_slot,
  output logic [DW-1:0]            r_data
);
  logic [GROUP-1:0][DW-1:0] col_q;
  logic [SW-1:0]            slot_q;

  for (genvar g = 0; g < GROUP; g++) begin : g_col
    logic [DW-1:0] col [ROWS];
    always_ff @(posedge clk) begin
      if (w_valid && w_en[g]) col[w_row] <= w_data[g];
      col_q[g] <= col[r_row];
    end
  end

  always_ff @(posedge clk) slot_q <= r_slot;

  assign r_data = col_q[slot_q];
endmodule

// File: rtl/fieldmem_wr_port.sv
module fieldmem_wr_port
  import fmw_pkg::*;
#(
  parameter int DATA_W     = FMW_DATA_W,
  parameter int DEPTH      = FMW_DEPTH,
  parameter int GROUP      = FMW_GROUP,
  parameter int MIN_ACTIVE = FMW_MIN_RUN,
  parameter int AW         = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  input  logic              wr_restart,
  input  logic              wr_en,
  input  logic              in_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [AW-1:0]     wr_ptr,
  output logic              err_spacing,
  output logic              err_short
);
  localparam int SW   = $clog2(GROUP);
  localparam int RW   = AW - SW;
  localparam int ROWS = DEPTH / GROUP;

  logic                         capture, flush;
  logic                         stage_pending;
  logic                         commit_valid;
  logic [RW-1:0]                commit_row;
  logic [GROUP-1:0]             commit_we;
  logic [GROUP-1:0][DATA_W-1:0] commit_data;

  fmw_ctrl #(.DEPTH(DEPTH), .MIN_ACTIVE(MIN_ACTIVE), .AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .wr_restart(wr_restart), .wr_en(wr_en),
    .ptr(wr_ptr), .capture(capture), .flush(flush),
    .err_spacing(err_spacing), .err_short(err_short)
  );

  fmw_stage #(.DW(DATA_W), .GROUP(GROUP), .SW(SW), .RW(RW)) u_stage (
    .clk(clk), .rst(rst), .capture(capture), .flush(flush),
    .din(din), .ien(in_en), .slot(wr_ptr[SW-1:0]), .row(wr_ptr[AW-1:SW]),
    .pending(stage_pending), .c_valid(commit_valid), .c_row(commit_row),
    .c_we(commit_we), .c_data(commit_data)
  );

  fmw_array #(.DW(DATA_W), .GROUP(GROUP), .ROWS(ROWS), .SW(SW), .RW(RW)) u_array (
    .clk(clk), .w_valid(commit_valid), .w_row(commit_row), .w_en(commit_we),
    .w_data(commit_data), .r_row(rd_addr[AW-1:SW]), .r_slot(rd_addr[SW-1:0]),
    .r_data(rd_data)
  );
endmodule

// File: rtl/fmw_checker.sv
module fmw_checker #(
  parameter int DEPTH = 256,
  parameter int GROUP = 8,
  parameter int AW    = $clog2(DEPTH),
  parameter int SW    = $clog2(GROUP),
  parameter int RW    = AW - SW
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_restart,
  input logic          wr_en,
  input logic [AW-1:0] wr_ptr,
  input logic          err_spacing,
  input logic          err_short,
  input logic          stage_pending,
  input logic          commit_valid,
  input logic [RW-1:0] commit_row
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  logic [1:0] seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= 2'd0;
    else if (seen != 2'd2) seen <= seen + 2'd1;
  end

  a_r2_restart_clears: assert property (@(posedge clk) disable iff (rst)
    wr_restart |=> (wr_ptr == '0));
  a_r4_ptr_holds: assert property (@(posedge clk) disable iff (rst)
    (!wr_restart && !wr_en) |=> $stable(wr_ptr));
  a_r4_ptr_steps: assert property (@(posedge clk) disable iff (rst)
    (!wr_restart && wr_en && wr_ptr != LAST) |=> (wr_ptr == $past(wr_ptr) + AW'(1)));
  a_r6_ptr_wraps: assert property (@(posedge clk) disable iff (rst)
    (!wr_restart && wr_en && wr_ptr == LAST) |=> (wr_ptr == '0));
  a_r3_spacing_flag: assert property (@(posedge clk) disable iff (rst)
    (seen == 2'd2 && wr_restart && !$past(wr_restart) && $past(wr_restart, 2)) |=> err_spacing);
  a_r3_spacing_sticky: assert property (@(posedge clk) disable iff (rst)
    err_spacing |=> err_spacing);
  a_r7_short_sticky: assert property (@(posedge clk) disable iff (rst)
    err_short |=> err_short);
  a_r8_group_commit: assert property (@(posedge clk) disable iff (rst)
    (!wr_restart && wr_en && (&wr_ptr[SW-1:0]))
      |=> (commit_valid && commit_row == $past(wr_ptr[AW-1:SW])));
  a_r9_flush_old_row: assert property (@(posedge clk) disable iff (rst)
    (wr_restart && stage_pending)
      |=> (commit_valid && commit_row == $past(wr_ptr[AW-1:SW])));
  a_r9_no_spurious_commit: assert property (@(posedge clk) disable iff (rst)
    (!(wr_restart && stage_pending) && !(!wr_restart && wr_en && (&wr_ptr[SW-1:0])))
      |=> !commit_valid);
endmodule

bind fieldmem_wr_port fmw_checker #(.DEPTH(DEPTH), .GROUP(GROUP)) u_chk (
  .clk(clk), .rst(rst), .wr_restart(wr_restart), .wr_en(wr_en), .wr_ptr(wr_ptr),
  .err_spacing(err_spacing), .err_short(err_short), .stage_pending(stage_pending),
  .commit_valid(commit_valid), .commit_row(commit_row)
);

// File: tb/fieldmem_wr_port_tb.sv
`timescale 1ns/1ps
module fieldmem_wr_port_tb;
  localparam int DW = 12;
  localparam int DEPTH = 256;
  localparam int G = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1;
  logic [DW-1:0] din = '0;
  logic          wr_restart = 1'b0, wr_en = 1'b0, in_en = 1'b0;
  logic [7:0]    rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic [7:0]    wr_ptr;
  logic          err_spacing, err_short;

  fieldmem_wr_port u_dut (
    .clk(clk), .rst(rst), .din(din), .wr_restart(wr_restart), .wr_en(wr_en),
    .in_en(in_en), .rd_addr(rd_addr), .rd_data(rd_data), .wr_ptr(wr_ptr),
    .err_spacing(err_spacing), .err_short(err_short)
  );

  int checks = 0, fails = 0;
  logic [DW-1:0] exp_mem [DEPTH];
  logic [DW-1:0] st_d [G];
  bit            st_w [G];
  int            m_ptr = 0;

  function automatic logic [DW-1:0] pat(int lap, int i);
    return DW'((lap * 37 + i * 5 + 1) & 12'hFFF);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic commit_row(int r);
    for (int g = 0; g < G; g++) begin
      if (st_w[g]) exp_mem[r * G + g] = st_d[g];
      st_w[g] = 1'b0;
    end
  endtask

  task automatic wr_word(logic [DW-1:0] d, bit ie);
    int slot;
    wr_restart = 1'b0; wr_en = 1'b1; in_en = ie; din = d;
    step();
    slot = m_ptr % G;
    st_d[slot] = d;
    st_w[slot] = ie;
    if (slot == G - 1) commit_row(m_ptr / G);
    m_ptr = (m_ptr + 1) % DEPTH;
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    wr_en = 1'b0; wr_restart = 1'b0;
    for (int k = 0; k < n; k++) begin
      din = DW'(k * 291 + 7);
      step();
    end
  endtask

  // restart edge with garbage on data and enables (must be ignored)
  task automatic wr_reset();
    wr_restart = 1'b1; wr_en = 1'b1; in_en = 1'b1; din = 12'hFFF;
    step();
    commit_row(m_ptr / G);
    m_ptr = 0;
    wr_restart = 1'b0; wr_en = 1'b0;
    step();
    step();
  endtask

  task automatic sys_reset();
    rst = 1'b1; wr_en = 1'b0; wr_restart = 1'b0;
    step();
    step();
    rst = 1'b0;
    for (int g = 0; g < G; g++) st_w[g] = 1'b0;
    m_ptr = 0;
  endtask

  task automatic rd_chk(string req, int a);
    wr_en = 1'b0; wr_restart = 1'b0;
    rd_addr = 8'(a);
    step();
    chk(req, rd_data, exp_mem[a]);
  endtask

  task automatic t_reset_state();
    sys_reset();
    chk("R1 ptr after reset", wr_ptr, 0);
    chk("R1 err_spacing after reset", err_spacing, 0);
    chk("R1 err_short after reset", err_short, 0);
  endtask

  task automatic t_full_lap();
    wr_reset();
    for (int i = 0; i < DEPTH; i++) wr_word(pat(1, i), 1'b1);
    chk("R6 pointer wrapped to 0", wr_ptr, 0);
    for (int i = 0; i < 4; i++) wr_word(pat(2, i), 1'b1);
    chk("R6 pointer after wrap", wr_ptr, 4);
    wr_reset();
    chk("R7 long sequence no err_short", err_short, 0);
    for (int a = 0; a < DEPTH; a++) rd_chk("R8 array after full lap", a);
  endtask

  task automatic t_latency_masks_flush();
    logic [DW-1:0] old_v;
    for (int i = 0; i < 7; i++) wr_word(pat(3, i), 1'b1);
    rd_addr = 8'd3;
    old_v = exp_mem[3];
    wr_word(pat(3, 7), 1'b1);           // edge k captures last word of group 0
    step();                              // edge k+1: commit, read returns old word
    chk("R10 read during commit edge is old", rd_data, old_v);
    step();                              // edge k+2: new word visible
    chk("R8 group committed one edge after last word", rd_data, pat(3, 3));
    for (int i = 8; i < 20; i++) wr_word(pat(3, i), 1'b1);
    for (int i = 20; i < 24; i++) wr_word(pat(3, i), 1'b0);
    chk("R5 pointer advances with in_en low", wr_ptr, 24);
    idle(5);
    chk("R4 pointer holds with wr_en low", wr_ptr, 24);
    for (int i = 24; i < 83; i++) wr_word(pat(3, i), 1'b1);
    chk("R4 pointer after 83 words", wr_ptr, 83);
    rd_chk("R9 staged word not yet in array", 81);
    wr_reset();
    chk("R2 pointer cleared by restart", wr_ptr, 0);
    chk("R7 83 actives no err_short", err_short, 0);
    rd_chk("R9 flushed word 80", 80);
    rd_chk("R9 flushed word 81", 81);
    rd_chk("R9 flushed word 82", 82);
    for (int a = 20; a < 24; a++) rd_chk("R5 masked address kept old word", a);
    rd_chk("R2 restart edge data ignored at addr 0", 0);
    rd_chk("R8 address 40", 40);
  endtask

  task automatic t_min_length();
    for (int i = 0; i < 80; i++) wr_word(pat(4, i), 1'b1);
    wr_reset();
    chk("R7 exactly 80 actives no err_short", err_short, 0);
    for (int i = 0; i < 79; i++) wr_word(pat(5, i), 1'b1);
    wr_reset();
    chk("R7 79 actives sets err_short", err_short, 1);
    chk("R3 spaced restarts no err_spacing", err_spacing, 0);
    rd_chk("R9 flush of 79-word tail", 78);
    for (int i = 0; i < 5; i++) wr_word(12'h5A5, 1'b1);
    sys_reset();
    chk("R1 err_short cleared", err_short, 0);
    wr_reset();
    chk("R7 first restart after reset not checked", err_short, 0);
    for (int a = 0; a < 5; a++) rd_chk("R1 staged words discarded", a);
  endtask

  task automatic t_spacing();
    sys_reset();
    wr_restart = 1'b1; step();
    wr_restart = 1'b0; step();
    wr_restart = 1'b1; step();
    wr_restart = 1'b0; step();
    chk("R3 one low cycle sets err_spacing", err_spacing, 1);
    sys_reset();
    chk("R1 err_spacing cleared", err_spacing, 0);
    wr_restart = 1'b1; step();
    wr_restart = 1'b0; step(); step();
    wr_restart = 1'b1; step();
    wr_restart = 1'b0; step();
    chk("R3 two low cycles no err_spacing", err_spacing, 0);
  endtask

  initial begin
    for (int g = 0; g < G; g++) st_w[g] = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_full_lap();
    t_latency_masks_flush();
    t_min_length();
    t_spacing();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule